// File: doc/BRIEF.md
# MSI Message Dispatcher

This block turns interrupt requests from a function's internal logic into message-signalled interrupt writes. Each request arrives as a vector number with a valid strobe. The block checks it against the number of vectors that software has enabled. It then either raises an error flag, records the vector as pending because its mask bit is set, or builds a single 32-bit memory write. That write goes out on a valid/ready master port together with the requester identifier.

The capability register file supplies the configuration as plain level inputs: the enable bit, the addressing and masking capabilities, the requested and capable vector counts, the address words, the data word and the mask bits. The pending bits live in this block and are exported for the register file to show. A pulse on `cfg_write` marks a configuration write. After such a write, with messages enabled and masking supported, the block first drops pending bits that now lie outside the enabled range. It then replays every pending vector that is no longer masked, lowest vector first.

Only one write is in flight at a time. While a write waits for `wr_ready`, or while a replay scan is running, `req_ready` is low.

Top module: `msi_dispatch`

## Requirements
- R1: A request accepted while enabled, whose vector is not below the enabled count N, pulses `req_err` for one cycle in the cycle after acceptance, and produces no write.
- R2: With masking supported (`cfg_maskable`=1) and the vector's bit set in `cfg_mask` (bit i belongs to vector i), an accepted request sets bit i of `pend_bits` and produces no write.
- R3: `wr_addr` is {`cfg_addr_hi`, `cfg_addr_lo` with bits 1:0 cleared} when `cfg_addr64`=1, and otherwise {32'h0, `cfg_addr_lo` with bits 1:0 cleared}.
- R4: `wr_data[31:16]` is zero. `wr_data[15:0]` is `cfg_data` with its low log2(N) bits replaced by the low log2(N) bits of the vector number. When N=1, `cfg_data` passes unchanged.
- R5: `wr_rid` equals {`bus_num`, `dev_fn`}, with the bus number in bits 15:8.
- R6: `wr_data` is little-endian: bits 8k+7:8k hold the byte for address `wr_addr`+k, so bits 7:0 carry the low byte of the message value.
- R7: After `cfg_write` while enabled and maskable, every vector below N that is pending and unmasked is delivered in ascending vector order, and its pending bit is cleared.
- R8: On `cfg_write` while enabled and maskable, pending bits at or above N are discarded without being delivered.
- R9: With `cfg_maskable`=0, `cfg_mask` is ignored, every legal request is delivered, no pending bit is ever set, and `cfg_write` starts no replay.
- R10: Requests accepted while `cfg_enable`=0 are dropped, with no write, no error and no pending bit.
- R11: While a write is held by `wr_ready`=0, `wr_valid` stays high with stable address, data and identifier, and `req_ready` is low.
- R12: The enabled count N is 2^min(`cfg_log_req`, `cfg_log_cap`, log2(MAX_VEC)). The 3-bit fields hold log2 of the count.
- R13: After reset, `wr_valid`=0, `req_err`=0, `pend_bits`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Message interrupts enabled |
| cfg_addr64 | input | 1 | 64-bit address capability |
| cfg_maskable | input | 1 | Per-vector masking capability |
| cfg_log_cap | input | 3 | log2 of vectors the function can use |
| cfg_log_req | input | 3 | log2 of vectors software enabled |
| cfg_addr_lo | input | 32 | Message address, low word |
| cfg_addr_hi | input | 32 | Message address, high word |
| cfg_data | input | 16 | Message data base value |
| cfg_mask | input | MAX_VEC | Per-vector mask bits |
| cfg_write | input | 1 | One-cycle pulse: a configuration write occurred |
| bus_num | input | 8 | Bus number |
| dev_fn | input | 8 | Device/function number |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | $clog2(MAX_VEC) | Requested vector number |
| req_ready | output | 1 | Request can be accepted |
| req_err | output | 1 | Illegal-vector pulse |
| pend_bits | output | MAX_VEC | Pending vector bits |
| wr_valid | output | 1 | Memory write request valid |
| wr_ready | input | 1 | Memory write accepted |
| wr_addr | output | 64 | Write address |
| wr_data | output | 32 | Write data, little-endian lanes |
| wr_rid | output | 16 | Requester identifier |

## Verification
Legal vectors are sent with one, four and eight enabled vectors, each against a data base with known low bits. This separates clearing the low bits from merging in the vector, and it separates the requested count from the capable count. Out-of-range vectors, masked vectors, a disabled block and a function without masking each show a different non-delivery outcome: an error, a pending bit, silence, or a delivery that ignores the mask. A replay over several pending vectors, with some of them still masked, checks the delivery order and which pending bits survive. Shrinking N before a second replay shows that out-of-range pending bits are dropped. Running with a stalling `wr_ready` tells a held write apart from a repeated or lost one.

// File: rtl/msi_pkg.sv
package msi_pkg;

    // One outgoing message write.
    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
        logic [15:0] rid;
    } msi_wr_t;

endpackage

// File: rtl/msi_vec_limit.sv
// Works out the enabled vector count (as log2) and a bit per legal vector.
module msi_vec_limit #(
    parameter int MAX_VEC = 32,
    parameter int LOG_W   = 3
) (
    input  logic [LOG_W-1:0]   log_req,
    input  logic [LOG_W-1:0]   log_cap,
    output logic [LOG_W-1:0]   n_log,
    output logic [MAX_VEC-1:0] en_bits
);
    localparam int MAX_LOG = $clog2(MAX_VEC);

    logic [LOG_W-1:0] pick;

    always_comb begin
        pick = (log_req < log_cap) ? log_req : log_cap;
        if (pick > LOG_W'(MAX_LOG)) begin
            pick = LOG_W'(MAX_LOG);
        end
        n_log = pick;
    end

    for (genvar i = 0; i < MAX_VEC; i++) begin : g_en
        assign en_bits[i] = (32'(i) < (32'd1 << n_log));
    end

endmodule

// File: rtl/msi_lowest.sv
// Finds the lowest set bit of a vector.
module msi_lowest #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/msi_msg_form.sv
// Builds address, data and requester identifier for one vector.
module msi_msg_form
    import msi_pkg::*;
#(
    parameter int VW    = 5,
    parameter int LOG_W = 3
) (
    input  logic             addr64,
    input  logic [31:0]      addr_lo,
    input  logic [31:0]      addr_hi,
    input  logic [15:0]      data_base,
    input  logic [LOG_W-1:0] n_log,
    input  logic [VW-1:0]    vec,
    input  logic [7:0]       bus_num,
    input  logic [7:0]       dev_fn,
    output msi_wr_t          msg
);
    logic [15:0] low_mask;
    logic [15:0] vec16;
    logic [31:0] lo_al;

    always_comb begin
        low_mask = (16'd1 << n_log) - 16'd1;
        vec16    = {{(16 - VW){1'b0}}, vec};
        lo_al    = addr_lo & 32'hFFFF_FFFC;
        msg.addr = addr64 ? {addr_hi, lo_al} : {32'h0, lo_al};
        // Lane k (bits 8k+7:8k) is the byte for address + k.
        msg.data = {16'h0, (data_base & ~low_mask) | (vec16 & low_mask)};
        msg.rid  = {bus_num, dev_fn};
    end

endmodule

// File: rtl/msi_dispatch.sv
module msi_dispatch
    import msi_pkg::*;
#(
    parameter int MAX_VEC = 32,
    parameter int LOG_W   = 3,
    localparam int VW     = $clog2(MAX_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic               cfg_addr64,
    input  logic               cfg_maskable,
    input  logic [LOG_W-1:0]   cfg_log_cap,
    input  logic [LOG_W-1:0]   cfg_log_req,
    input  logic [31:0]        cfg_addr_lo,
    input  logic [31:0]        cfg_addr_hi,
    input  logic [15:0]        cfg_data,
    input  logic [MAX_VEC-1:0] cfg_mask,
    input  logic               cfg_write,
    input  logic [7:0]         bus_num,
    input  logic [7:0]         dev_fn,
    input  logic               req_valid,
    input  logic [VW-1:0]      req_vec,
    output logic               req_ready,
    output logic               req_err,
    output logic [MAX_VEC-1:0] pend_bits,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [63:0]        wr_addr,
    output logic [31:0]        wr_data,
    output logic [15:0]        wr_rid
);
    typedef struct packed {
        logic               busy;
        msi_wr_t            wr;
        logic [MAX_VEC-1:0] pend;
        logic               scan;
        logic               err;
    } state_t;

    state_t st_d, st_q;

    logic [LOG_W-1:0]   n_log;
    logic [MAX_VEC-1:0] en_bits;
    logic [MAX_VEC-1:0] cand;
    logic               cand_found;
    logic [VW-1:0]      cand_idx;
    logic [VW-1:0]      vec_sel;
    logic               take;
    logic               scan_go;
    msi_wr_t            msg;

    msi_vec_limit #(.MAX_VEC(MAX_VEC), .LOG_W(LOG_W)) u_limit (
        .log_req (cfg_log_req),
        .log_cap (cfg_log_cap),
        .n_log   (n_log),
        .en_bits (en_bits)
    );

    assign cand = st_q.pend & ~cfg_mask & en_bits;

    msi_lowest #(.W(MAX_VEC), .IW(VW)) u_low (
        .bits  (cand),
        .found (cand_found),
        .idx   (cand_idx)
    );

    msi_msg_form #(.VW(VW), .LOG_W(LOG_W)) u_form (
        .addr64    (cfg_addr64),
        .addr_lo   (cfg_addr_lo),
        .addr_hi   (cfg_addr_hi),
        .data_base (cfg_data),
        .n_log     (n_log),
        .vec       (vec_sel),
        .bus_num   (bus_num),
        .dev_fn    (dev_fn),
        .msg       (msg)
    );

    assign req_ready = !st_q.busy && !st_q.scan;
    assign take      = req_valid && req_ready;
    assign scan_go   = st_q.scan && !st_q.busy && cfg_enable && cfg_maskable;
    assign vec_sel   = scan_go ? cand_idx : req_vec;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;

        if (st_q.busy && wr_ready) begin
            st_d.busy = 1'b0;
        end

        // New request from function logic.
        if (take && cfg_enable) begin
            if (!en_bits[req_vec]) begin
                st_d.err = 1'b1;
            end else if (cfg_maskable && cfg_mask[req_vec]) begin
                st_d.pend[req_vec] = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                st_d.wr   = msg;
            end
        end

        // Replay of unmasked pending vectors, lowest first.
        if (scan_go) begin
            if (cand_found) begin
                st_d.pend[cand_idx] = 1'b0;
                st_d.busy           = 1'b1;
                st_d.wr             = msg;
            end else begin
                st_d.scan = 1'b0;
            end
        end

        if (!cfg_enable || !cfg_maskable) begin
            st_d.scan = 1'b0;
        end

        // A configuration write trims out-of-range pending bits and rescans.
        if (cfg_write && cfg_enable && cfg_maskable) begin
            st_d.pend = st_d.pend & en_bits;
            st_d.scan = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_err   = st_q.err;
    assign pend_bits = st_q.pend;
    assign wr_valid  = st_q.busy;
    assign wr_addr   = st_q.wr.addr;
    assign wr_data   = st_q.wr.data;
    assign wr_rid    = st_q.wr.rid;

    // R11: a stalled write holds its contents.
    assert_write_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_rid)));

    // R1: an error pulse follows an accepted request and starts no write.
    assert_err_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> ($past(req_valid && req_ready && cfg_enable) && !wr_valid));

    // R4: upper half of the message data is always zero.
    assert_data_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_data[31:16] == 16'h0));

    // R9: without masking capability no pending bit rises.
    assert_no_new_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_maskable) |-> ((pend_bits & ~$past(pend_bits)) == '0));

    // R10: nothing new is issued while disabled.
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_enable && !wr_valid) |-> !wr_valid);

    // R8: after a trimming configuration write no out-of-range bit remains.
    assert_trim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_write && cfg_enable && cfg_maskable) |-> ((pend_bits & ~$past(en_bits)) == '0));

endmodule

// File: tb/msi_dispatch_test.sv
module msi_dispatch_test;
    import msi_pkg::*;

    localparam int MAX_VEC = 32;
    localparam int VW      = $clog2(MAX_VEC);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b0, cfg_addr64 = 1'b0, cfg_maskable = 1'b0;
    logic [2:0] cfg_log_cap = 3'd0, cfg_log_req = 3'd0;
    logic [31:0] cfg_addr_lo = '0, cfg_addr_hi = '0;
    logic [15:0] cfg_data = '0;
    logic [MAX_VEC-1:0] cfg_mask = '0;
    logic cfg_write = 1'b0;
    logic [7:0] bus_num = '0, dev_fn = '0;
    logic req_valid = 1'b0;
    logic [VW-1:0] req_vec = '0;
    logic req_ready, req_err, wr_valid, wr_ready;
    logic [MAX_VEC-1:0] pend_bits;
    logic [63:0] wr_addr;
    logic [31:0] wr_data;
    logic [15:0] wr_rid;

    int checks = 0;
    int errors = 0;
    int rmode = 0;
    int unsigned cyc = 0;
    msi_wr_t expq[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;
    assign wr_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 3 == 2) : 1'b0;

    msi_dispatch #(.MAX_VEC(MAX_VEC)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_addr64(cfg_addr64),
        .cfg_maskable(cfg_maskable), .cfg_log_cap(cfg_log_cap), .cfg_log_req(cfg_log_req),
        .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi), .cfg_data(cfg_data),
        .cfg_mask(cfg_mask), .cfg_write(cfg_write), .bus_num(bus_num), .dev_fn(dev_fn),
        .req_valid(req_valid), .req_vec(req_vec), .req_ready(req_ready), .req_err(req_err),
        .pend_bits(pend_bits), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_rid(wr_rid)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bench model of the message for one vector.
    function automatic msi_wr_t model(input int vec);
        msi_wr_t m;
        int nl;
        logic [15:0] lm;
        nl = (cfg_log_req < cfg_log_cap) ? int'(cfg_log_req) : int'(cfg_log_cap);
        if (nl > VW) nl = VW;
        lm = 16'((1 << nl) - 1);
        m.addr = cfg_addr64 ? {cfg_addr_hi, cfg_addr_lo & 32'hFFFF_FFFC}
                            : {32'h0, cfg_addr_lo & 32'hFFFF_FFFC};
        m.data = {16'h0, (cfg_data & ~lm) | (16'(vec) & lm)};
        m.rid  = {bus_num, dev_fn};
        return m;
    endfunction

    // Monitor: compare each accepted write with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R1/R2/R9/R10 unexpected write actual=%h expected=none",
                         {wr_addr, wr_data, wr_rid});
            end else begin
                msi_wr_t e;
                e = expq.pop_front();
                if ({wr_addr, wr_data, wr_rid} !== e) begin
                    errors++;
                    $display("FAIL R3/R4/R5/R7 write actual=%h expected=%h",
                             {wr_addr, wr_data, wr_rid}, e);
                end
            end
        end
    end

    // Driver: send one request; push the expected write if one should follow.
    task automatic send(input int vec, input bit deliver, input bit exp_err, input string tag);
        while (!req_ready) @(negedge clk);
        if (deliver) expq.push_back(model(vec));
        req_valid = 1'b1;
        req_vec   = VW'(vec);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " req_err"}, 64'(req_err), 64'(exp_err));
    endtask

    task automatic drain();
        int n = 0;
        while ((expq.size() != 0 || wr_valid || !req_ready) && n < 200) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check("queue empty", 64'(expq.size()), 64'd0);
    endtask

    task automatic cfg_pulse();
        cfg_write = 1'b1;
        @(negedge clk);
        cfg_write = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 wr_valid", 64'(wr_valid), 64'd0);
        check("R13 pend", 64'(pend_bits), 64'd0);
        check("R13 err", 64'(req_err), 64'd0);
        check("R13 ready", 64'(req_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        cfg_enable = 1; cfg_addr64 = 0; cfg_maskable = 1;
        cfg_log_cap = 5; cfg_log_req = 3;
        cfg_addr_lo = 32'hFEE0_1237; cfg_addr_hi = 32'hDEAD_BEEF;
        cfg_data = 16'h4A5F; bus_num = 8'h3C; dev_fn = 8'h91;

        // R3 32-bit address, R4 merge, R5 rid, R6 lane 0
        send(5, 1, 0, "R3 R4 R5 vec5");
        @(negedge clk);
        check("R6 lane0", 64'(wr_data[7:0]), 64'h5D);
        check("R5 rid", 64'(wr_rid), 64'h3C91);
        drain();

        // R3 64-bit address
        cfg_addr64 = 1;
        send(0, 1, 0, "R3 vec0 64b");
        drain();

        // R11 stall: held write, no new request taken
        rmode = 2;
        send(6, 1, 0, "R11 vec6");
        repeat (3) begin
            @(negedge clk);
            check("R11 valid held", 64'(wr_valid), 64'd1);
            check("R11 ready low", 64'(req_ready), 64'd0);
            check("R11 data held", 64'(wr_data), 64'h4A5E);
        end
        rmode = 1;
        send(3, 1, 0, "R11 vec3");
        send(1, 1, 0, "R11 vec1");
        drain();
        rmode = 0;

        // R4 single vector: data unchanged; R1 vector 1 illegal
        cfg_log_req = 0;
        send(0, 1, 0, "R4 N=1");
        drain();
        send(1, 0, 1, "R1 vec1 N=1");
        drain();

        // R12 clamp: requested 32, capable 4
        cfg_log_req = 5; cfg_log_cap = 2; cfg_data = 16'h4A5C;
        send(3, 1, 0, "R12 vec3");
        send(2, 1, 0, "R12 vec2");
        drain();
        send(4, 0, 1, "R12 R1 vec4");
        drain();

        // R10 disabled
        cfg_enable = 0;
        send(1, 0, 0, "R10 disabled");
        drain();
        check("R10 pend", 64'(pend_bits), 64'd0);
        cfg_enable = 1;

        // R2 masking, then R7 replay and R8 trim
        cfg_log_cap = 5; cfg_log_req = 3; cfg_mask = '1;
        send(7, 0, 0, "R2 vec7");
        send(2, 0, 0, "R2 vec2");
        send(5, 0, 0, "R2 vec5");
        drain();
        check("R2 pend", 64'(pend_bits), 64'h0A4);
        cfg_mask = ~32'h0000_00A0;
        expq.push_back(model(5));
        expq.push_back(model(7));
        cfg_pulse();
        drain();
        check("R7 pend left", 64'(pend_bits), 64'h004);
        cfg_log_req = 1; cfg_mask = '0;
        cfg_pulse();
        drain();
        check("R8 pend trimmed", 64'(pend_bits), 64'h0);

        // R9 no masking capability
        cfg_maskable = 0; cfg_log_req = 3; cfg_mask = '1;
        send(1, 1, 0, "R9 vec1");
        drain();
        check("R9 pend", 64'(pend_bits), 64'h0);
        cfg_pulse();
        drain();
        check("R9 ready", 64'(req_ready), 64'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule